// File: doc/BRIEF.md
# Channel-Status Block Marker and Per-Frame Flag Timing

This block sits behind a digital audio receiver's frame decoder and in front of its serial audio port. For every frame it takes one record, which holds the channel-status bit, the user bit, the validity bit, two error flags for the sample and a marker that says a block-start preamble was seen. It turns each record into five serial-side outputs: the channel-status bit, the user bit, a block-lead marker, an error flag and a "sample suspect" flag. Each output changes at a defined point relative to the audio port's frame sync.

A 192-frame counter tracks the position inside a channel-status block. The block-lead marker is high for the first 32 frames of each block and low for the other 160. A block-start record forces the count to zero. When no block-start record arrives, the count wraps on its own, so the marker stays periodic.

Records enter through a valid/ready handshake into a one-entry slot. The slot is emptied at the point where the channel-status outputs update. A producer holds `in_valid` and the record fields steady until it sees `in_valid && in_ready` at a rising clock edge. The block never takes a second record before the first one has been used. The port timing arrives as single-cycle strobes in the `clk` domain:
- `sck_tick` marks each serial bit clock.
- `fsync_edge` marks the active frame-sync edge and always coincides with a `sck_tick`.

Top module: `cs_flag_timing`

## Requirements
- R1: `blk_lead` is high for frame indices 0 to 31 and low for indices 32 to 191, and the index runs over 192 frames per block.
- R2: Using a record whose `in_blk_start` is 1 sets that frame's index to 0, whatever the count was before.
- R3: When no block-start record arrives, the index advances by one per used frame and wraps from 191 to 0. After reset, the first frame used gets index 0.
- R4: With `i2s_mode` = 0, `chs_bit`, `usr_bit` and `blk_lead` change only in the clock after the `sck_tick` that comes SCK_PER_FRAME-1 ticks after the last `fsync_edge`. That tick is one bit clock before the next frame-sync edge.
- R5: With `i2s_mode` = 1, `chs_bit`, `usr_bit` and `blk_lead` change only in the clock after `fsync_edge`.
- R6: In both modes, `err_flag` and `suspect_flag` change only in the clock after `fsync_edge`. With `i2s_mode` = 0, they show the flags captured at the preceding update tick.
- R7: `err_flag` for a frame is the OR of its parity error, its biphase error, and `locked` = 0 sampled at the frame's update point.
- R8: `suspect_flag` is the OR of the frame's validity bit and its `err_flag`.
- R9: `in_ready` is high exactly when the slot is empty. A record is taken on `in_valid && in_ready`, is held unchanged while the slot is full, and is released at the update point.
- R10: At an update point with an empty slot, the block uses an all-zero record: C, U and V are 0, there are no sample errors and no block start. The index still advances.
- R11: During and after reset, all five outputs are 0 and `in_ready` is 1.
- R12: Until the first `fsync_edge`, no update happens, however many `sck_tick` strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2s_mode | input | 1 | 1 selects update on the frame-sync edge for C/U/lead |
| sck_tick | input | 1 | One-cycle strobe per serial bit clock |
| fsync_edge | input | 1 | One-cycle strobe at the active frame-sync edge |
| locked | input | 1 | Receiver lock status, sampled at the update point |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Slot empty, record will be taken |
| in_blk_start | input | 1 | Record carries a block-start preamble |
| in_c | input | 1 | Channel-status bit of the frame |
| in_u | input | 1 | User bit of the frame |
| in_v | input | 1 | Validity bit of the frame |
| in_parity_err | input | 1 | Parity error in the sample |
| in_biphase_err | input | 1 | Biphase coding violation in the sample |
| chs_bit | output | 1 | Serial channel-status bit |
| usr_bit | output | 1 | Serial user bit |
| blk_lead | output | 1 | High during the first 32 frames of a block |
| err_flag | output | 1 | Serious error for the current sample |
| suspect_flag | output | 1 | Validity bit OR error flag |

## Verification
The conditions that are hardest to reach from the ports are these:
- the index wrapping from 191 to 0 with no block start;
- a block start arriving partway through a block;
- an update point that finds the slot empty.

The stimulus therefore runs hundreds of frames per mode. It places block-start records at fixed record numbers, one early and one mid-block, and leaves a long run without any, which crosses the wrap. Random producer gaps of several frames force empty-slot updates. Every output is compared on every bit clock against a bench model, so an update one tick early or late shows up at once. A run of bit clocks before the first frame-sync edge checks that nothing updates before synchronisation.

// File: rtl/cs_flag_pkg.sv
package cs_flag_pkg;

  // One received frame as presented to the flag timing block.
  typedef struct packed {
    logic blk_start;
    logic c;
    logic u;
    logic v;
    logic par_err;
    logic bip_err;
  } frame_rec_t;

endpackage

// File: rtl/cs_sck_phase.sv
// Tracks bit-clock position within a frame and marks the tick that is one
// bit clock ahead of the next expected frame-sync edge.
module cs_sck_phase #(
  parameter int SCK_PER_FRAME = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_tick,
  input  logic fsync_edge,
  output logic pre_tick,
  output logic synced
);
  localparam int CW = $clog2(SCK_PER_FRAME) + 1;
  localparam logic [CW-1:0] PRE_POS = CW'(SCK_PER_FRAME - 1);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      synced <= 1'b0;
    end else if (fsync_edge) begin
      pos_q  <= CW'(1);
      synced <= 1'b1;
    end else if (sck_tick && pos_q != CNT_MAX) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign pre_tick = synced && sck_tick && !fsync_edge && (pos_q == PRE_POS);

  // R4: the early update tick is a single strobe per frame
  a_r4_single_pre: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);

  // R12: once a sync edge is seen the tracker stays synchronised
  a_r12_sync_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_edge |=> synced);

endmodule

// File: rtl/cs_frame_index.sv
// Frame position within a channel-status block.
module cs_frame_index #(
  parameter int BLOCK_FRAMES = 192,
  parameter int LEAD_FRAMES  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic restart,
  output logic lead_next,
  output logic [$clog2(BLOCK_FRAMES)-1:0] idx
);
  localparam int IW = $clog2(BLOCK_FRAMES);
  localparam logic [IW-1:0] LAST_IDX = IW'(BLOCK_FRAMES - 1);
  localparam logic [IW-1:0] LEAD_END = IW'(LEAD_FRAMES);

  logic [IW-1:0] idx_next;

  always_comb begin
    if (restart || idx == LAST_IDX) idx_next = '0;
    else                            idx_next = idx + 1'b1;
  end

  assign lead_next = (idx_next < LEAD_END);

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= LAST_IDX;
    else if (advance) idx <= idx_next;
  end

  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);

  a_r3_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && idx == LAST_IDX) |=> idx == '0);

  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && restart) |=> idx == '0);

endmodule

// File: rtl/cs_rec_slot.sv
// One-entry record slot with valid/ready input; empty reads as all zero.
module cs_rec_slot
  import cs_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  frame_rec_t in_rec,
  input  logic       take,
  output frame_rec_t cur_rec
);
  logic       full_q;
  frame_rec_t data_q;

  assign in_ready = !full_q;
  assign cur_rec  = full_q ? data_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_rec;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r9_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !take) |=> (!in_ready && $stable(data_q)));

  a_r9_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && take) |=> in_ready);

endmodule

// File: rtl/cs_flag_timing.sv
module cs_flag_timing
  import cs_flag_pkg::*;
#(
  parameter int SCK_PER_FRAME = 64,
  parameter int BLOCK_FRAMES  = 192,
  parameter int LEAD_FRAMES   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_mode,
  input  logic sck_tick,
  input  logic fsync_edge,
  input  logic locked,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_blk_start,
  input  logic in_c,
  input  logic in_u,
  input  logic in_v,
  input  logic in_parity_err,
  input  logic in_biphase_err,
  output logic chs_bit,
  output logic usr_bit,
  output logic blk_lead,
  output logic err_flag,
  output logic suspect_flag
);
  localparam int IW = $clog2(BLOCK_FRAMES);
  localparam logic [IW-1:0] LEAD_END = IW'(LEAD_FRAMES);

  logic          pre_tick, synced, take, lead_next;
  logic [IW-1:0] idx;
  frame_rec_t    in_rec, cur_rec;
  logic          now_err, now_sus, pend_err, pend_sus;

  assign in_rec = '{blk_start: in_blk_start, c: in_c, u: in_u, v: in_v,
                    par_err: in_parity_err, bip_err: in_biphase_err};

  cs_sck_phase #(.SCK_PER_FRAME(SCK_PER_FRAME)) u_phase (
    .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick), .fsync_edge(fsync_edge),
    .pre_tick(pre_tick), .synced(synced));

  assign take = i2s_mode ? fsync_edge : pre_tick;

  cs_rec_slot u_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rec(in_rec), .take(take), .cur_rec(cur_rec));

  cs_frame_index #(.BLOCK_FRAMES(BLOCK_FRAMES), .LEAD_FRAMES(LEAD_FRAMES)) u_index (
    .clk(clk), .rst_n(rst_n), .advance(take), .restart(cur_rec.blk_start),
    .lead_next(lead_next), .idx(idx));

  assign now_err = cur_rec.par_err | cur_rec.bip_err | !locked;
  assign now_sus = cur_rec.v | now_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chs_bit      <= 1'b0;
      usr_bit      <= 1'b0;
      blk_lead     <= 1'b0;
      pend_err     <= 1'b0;
      pend_sus     <= 1'b0;
      err_flag     <= 1'b0;
      suspect_flag <= 1'b0;
    end else begin
      if (take) begin
        chs_bit  <= cur_rec.c;
        usr_bit  <= cur_rec.u;
        blk_lead <= lead_next;
        pend_err <= now_err;
        pend_sus <= now_sus;
      end
      if (fsync_edge) begin
        err_flag     <= i2s_mode ? now_err : pend_err;
        suspect_flag <= i2s_mode ? now_sus : pend_sus;
      end
    end
  end

  // R4, R5: serial C/U/lead move only at the selected update point
  a_r5_cu_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(chs_bit) && $stable(usr_bit) && $stable(blk_lead)));

  a_r6_flags_on_fsync: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync_edge |=> ($stable(err_flag) && $stable(suspect_flag)));

  a_r8_suspect_covers_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> suspect_flag);

  a_r1_lead_rises_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_lead) |-> idx == '0);

  a_r1_lead_falls_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_lead) |-> idx == LEAD_END);

  a_r12_no_update_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !fsync_edge) |=> ($stable(chs_bit) && $stable(blk_lead)));

endmodule

// File: tb/cs_flag_timing_test.sv
module cs_flag_timing_test;
  import cs_flag_pkg::*;

  localparam int N    = 8;
  localparam int BLK  = 192;
  localparam int LEAD = 32;
  localparam int PRE  = N + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, i2s_mode, sck_tick, fsync_edge, locked, in_valid, in_ready;
  logic chs_bit, usr_bit, blk_lead, err_flag, suspect_flag;
  frame_rec_t rec;

  cs_flag_timing #(.SCK_PER_FRAME(N), .BLOCK_FRAMES(BLK), .LEAD_FRAMES(LEAD)) uut (
    .clk(clk), .rst_n(rst_n), .i2s_mode(i2s_mode), .sck_tick(sck_tick),
    .fsync_edge(fsync_edge), .locked(locked), .in_valid(in_valid),
    .in_ready(in_ready), .in_blk_start(rec.blk_start), .in_c(rec.c),
    .in_u(rec.u), .in_v(rec.v), .in_parity_err(rec.par_err),
    .in_biphase_err(rec.bip_err), .chs_bit(chs_bit), .usr_bit(usr_bit),
    .blk_lead(blk_lead), .err_flag(err_flag), .suspect_flag(suspect_flag));

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic m_full, e_chs, e_usr, e_lead, e_err, e_sus, p_err, p_sus;
  frame_rec_t m_rec;
  int e_idx;
  string cu_tag, lead_tag, err_tag;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_idx(int i, logic bs);
    if (bs || i == BLK - 1) return 0;
    return i + 1;
  endfunction

  function automatic logic lead_of(int i);
    return i < LEAD;
  endfunction

  task automatic do_reset(logic mode);
    rst_n = 0; i2s_mode = mode; sck_tick = 0; fsync_edge = 0; locked = 1;
    in_valid = 0; rec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 chs", chs_bit, 1'b0);
    chk("R11 usr", usr_bit, 1'b0);
    chk("R11 lead", blk_lead, 1'b0);
    chk("R11 err", err_flag, 1'b0);
    chk("R11 suspect", suspect_flag, 1'b0);
    chk("R11 ready", in_ready, 1'b1);
    m_full = 0; m_rec = '0; e_idx = BLK - 1;
    {e_chs, e_usr, e_lead, e_err, e_sus, p_err, p_sus} = '0;
  endtask

  task automatic run_phase(logic mode, int frames, int bs_a, int bs_b);
    int rec_no = 0;
    int gap = 0;
    logic last_acc = 0;
    do_reset(mode);
    for (int tk = 0; tk < PRE + frames * N; tk++) begin
      for (int half = 0; half < 2; half++) begin
        logic fs, pre, take, acc, ne, ns;
        frame_rec_t cur;
        @(negedge clk);
        if (half == 1) begin
          chk(cu_tag, chs_bit, e_chs);
          chk(cu_tag, usr_bit, e_usr);
          chk(lead_tag, blk_lead, e_lead);
          chk(err_tag, err_flag, e_err);
          chk("R8 suspect", suspect_flag, e_sus);
          chk("R9 ready", in_ready, !m_full);
        end
        cu_tag   = (tk < PRE) ? "R12 c/u" : (mode ? "R5 c/u" : "R4 c/u");
        lead_tag = (tk < PRE) ? "R12 lead" : "R1 lead";
        err_tag  = mode ? "R7 err" : "R6 err";
        // producer
        if (last_acc) begin
          in_valid = 0;
          gap = ($urandom % 8 == 0) ? 4 * N * 2 : 0;
        end else if (gap > 0) begin
          gap--;
        end else if (!in_valid) begin
          rec_no++;
          rec.blk_start = (rec_no == bs_a) || (rec_no == bs_b);
          rec.c = 1'($urandom); rec.u = 1'($urandom);
          rec.v = ($urandom % 4 == 0);
          rec.par_err = ($urandom % 8 == 0);
          rec.bip_err = ($urandom % 8 == 0);
          in_valid = 1;
        end
        // port timing
        fs  = (half == 0) && tk >= PRE && ((tk - PRE) % N == 0);
        pre = (half == 0) && tk > PRE && ((tk - PRE) % N == N - 1);
        sck_tick = (half == 0);
        fsync_edge = fs;
        if (fs) locked = ($urandom % 16 != 0);
        // model of the coming edge
        take = mode ? fs : pre;
        acc  = in_valid && !m_full;
        cur  = m_full ? m_rec : '0;
        ne   = cur.par_err | cur.bip_err | !locked;
        ns   = cur.v | ne;
        if (fs) begin
          e_err = mode ? ne : p_err;
          e_sus = mode ? ns : p_sus;
          err_tag = "R7 err";
        end
        if (take) begin
          if (!m_full) cu_tag = "R10 empty";
          if (cur.blk_start) lead_tag = "R2 restart";
          else if (e_idx == BLK - 1) lead_tag = "R3 wrap";
          e_idx = next_idx(e_idx, cur.blk_start);
          e_chs = cur.c; e_usr = cur.u; e_lead = lead_of(e_idx);
          p_err = ne; p_sus = ns;
          m_full = 0;
        end
        if (acc) begin
          m_full = 1;
          m_rec = rec;
        end
        last_acc = acc;
      end
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd2718));
    run_phase(1'b0, 450, 5, 100);
    run_phase(1'b1, 300, 3, 250);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

endmodule